// File: doc/BRIEF.md
# Reconfigurable Partial-Sum Adder for a Column-Streaming Convolution Array

This block reduces the products of a W×H multiplier array into partial sums for the filter size that is currently configured. There are two reduction directions. A vertical group is k consecutive rows in one column, and each column has its own column adder. A horizontal group is k consecutive columns in one row, and each row has its own row adder.

Products from neighbouring columns of the array reach the block on different cycles, because data streams across the array one column per cycle. Each row adder therefore holds its earlier-arriving products in a per-column delay line. It then sums the operands that belong to the same input sample.

The configuration has three fields:
- **Filter size `k`:** the number of rows or columns in a group.
- **Streaming direction:** either forward (left to right) or reverse (right to left, with the window pinned to the rightmost columns).
- **Placement offset (variety):** where the window starts.

Products outside the selected window never reach an adder. Every partial sum carries its own valid flag, and that flag is delayed to match the path its sum took.

Top module: `psum_adder_top`

## Requirements
- R1: During and right after a synchronous active-high reset, every valid flag and every partial sum reads zero.
- R2: Vertical sum, valid configuration:
  - The configuration is valid when 3 ≤ k ≤ H and offset + k ≤ H.
  - One clock after products are presented, `vsum_o` slice x (bits x*SW +: SW) equals the signed sum of that sample's products in column x, rows offset to offset+k−1.
  - The product of row y, column x sits at bits (y*W+x)*PW +: PW of `prod_i`.
- R3: When the vertical configuration is not valid, every vertical sum is zero and every vertical valid flag is low.
- R4: Horizontal sum, forward direction (`dir_i`=0), for each row y:
  - The window covers columns offset to offset+k−1.
  - The product of column c is delayed offset+k−1−c cycles, so the leftmost column waits longest.
  - The aligned sum appears in `hsum_o` slice y one clock after the last delay.
- R5: Horizontal sum, reverse direction (`dir_i`=1):
  - The window is always columns W−k to W−1, and the offset input has no effect.
  - The product of column c is delayed c−(W−k) cycles, so the rightmost column waits longest.
- R6: Each vertical valid flag repeats the registered copy of `prod_valid_i`. Each horizontal valid flag repeats `prod_valid_i` from k clocks earlier. Both apply only when the configuration is valid.
- R7: In the forward direction, when offset + k > W, every horizontal sum is zero and every horizontal valid flag is low.
- R8: A filter size below 3, or above W for the rows (above H for the columns), yields zero sums and low valid flags on that side.
- R9: Products are two's-complement. Sums are sign-extended to SW bits, and a full-height or full-width group cannot overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prod_i | input | W*H*PW | Flattened product array, row-major, signed |
| prod_valid_i | input | 1 | Marks the products on `prod_i` as a real sample |
| ksize_i | input | KW | Filter size k |
| dir_i | input | 1 | 0 = forward streaming, 1 = reverse streaming |
| variety_i | input | KW | Placement offset of the window |
| vsum_o | output | W*SW | Vertical partial sum per column |
| vvalid_o | output | W | Valid flag per vertical sum |
| hsum_o | output | H*SW | Horizontal partial sum per row |
| hvalid_o | output | H | Valid flag per horizontal sum |

## Verification
The bench builds the block as a 5×5 array with 16-bit products and 20-bit sums. At that size it can sweep every filter size from an illegal 2 to an illegal 6, both directions, and every offset from 0 to 3. That sweep covers windows that fit exactly, windows that overrun by one, and every possible delay-tap depth in the row lines.

Random signed products and an irregular valid pattern are presented on every cycle, including the cycles right after a configuration change. Expected sums are computed from a history of the driven products, so misaligned delays and wrong window edges show up as numeric mismatches.

// File: rtl/psum_adder_pkg.sv
package psum_adder_pkg;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_REV = 1'b1
    } stream_dir_e;

    typedef struct packed {
        logic [7:0]  ksize;
        logic [7:0]  offset;
        stream_dir_e dir;
    } psum_cfg_t;

    function automatic logic size_ok(input int k, input int lim);
        return (k >= 3) && (k <= lim);
    endfunction

    function automatic logic window_fits(input int start, input int k, input int lim);
        return (start + k) <= lim;
    endfunction

endpackage

// File: rtl/psum_col_adder.sv
module psum_col_adder #(
    parameter int H  = 11,
    parameter int PW = 32,
    parameter int SW = 40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [H*PW-1:0] col_prod,
    input  logic [7:0]      ksize,
    input  logic [7:0]      offset,
    input  logic            pv,
    output logic [SW-1:0]   sum_q,
    output logic            vld_q
);
    import psum_adder_pkg::*;

    logic            cfg_ok;
    logic [SW-1:0]   acc;

    always_comb begin
        cfg_ok = size_ok(int'(ksize), H) && window_fits(int'(offset), int'(ksize), H);
        acc    = '0;
        for (int r = 0; r < H; r++) begin
            if (cfg_ok && (r >= int'(offset)) && (r < int'(offset) + int'(ksize))) begin
                acc = acc + {{(SW-PW){col_prod[r*PW+PW-1]}}, col_prod[r*PW +: PW]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            vld_q <= 1'b0;
        end else begin
            sum_q <= acc;
            vld_q <= pv && cfg_ok;
        end
    end

    // R3
    col_bad_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_ok |=> (sum_q == '0) && !vld_q);

    // R6
    col_valid_src_chk: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> $past(pv));

endmodule

// File: rtl/psum_row_adder.sv
module psum_row_adder #(
    parameter int W  = 11,
    parameter int PW = 32,
    parameter int SW = 40
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [W*PW-1:0]          row_prod,
    input  psum_adder_pkg::psum_cfg_t cfg,
    input  logic [W-1:0]             pv_taps,
    output logic [SW-1:0]            sum_q,
    output logic                     vld_q
);
    import psum_adder_pkg::*;

    localparam int DEPTH = W - 1;

    logic [PW-1:0] line [W][DEPTH];
    logic          cfg_ok;
    logic          vld_d;
    logic [SW-1:0] acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < W; c++) begin
                for (int d = 0; d < DEPTH; d++) line[c][d] <= '0;
            end
        end else begin
            for (int c = 0; c < W; c++) begin
                line[c][0] <= row_prod[c*PW +: PW];
                for (int d = 1; d < DEPTH; d++) line[c][d] <= line[c][d-1];
            end
        end
    end

    always_comb begin
        int            start;
        int            dly;
        logic [PW-1:0] tap;
        cfg_ok = size_ok(int'(cfg.ksize), W) &&
                 ((cfg.dir == DIR_REV) || window_fits(int'(cfg.offset), int'(cfg.ksize), W));
        start  = (cfg.dir == DIR_REV) ? (W - int'(cfg.ksize)) : int'(cfg.offset);
        acc    = '0;
        for (int c = 0; c < W; c++) begin
            dly = (cfg.dir == DIR_FWD) ? (start + int'(cfg.ksize) - 1 - c) : (c - start);
            tap = (dly <= 0) ? row_prod[c*PW +: PW] : line[c][(dly > DEPTH ? DEPTH : dly) - 1];
            if (cfg_ok && (c >= start) && (c < start + int'(cfg.ksize))) begin
                acc = acc + {{(SW-PW){tap[PW-1]}}, tap};
            end
        end
        vld_d = 1'b0;
        for (int d = 0; d < W; d++) begin
            if (cfg_ok && (d == int'(cfg.ksize) - 1)) vld_d = pv_taps[d];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            vld_q <= 1'b0;
        end else begin
            sum_q <= acc;
            vld_q <= vld_d;
        end
    end

    // R7
    row_bad_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_ok |=> (sum_q == '0) && !vld_q);

    // R6
    row_valid_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        vld_q |-> $past(cfg_ok));

endmodule

// File: rtl/psum_adder_top.sv
module psum_adder_top #(
    parameter int W  = 11,
    parameter int H  = 11,
    parameter int PW = 32,
    parameter int SW = 40,
    localparam int KW = $clog2(((W > H) ? W : H) + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W*H*PW-1:0] prod_i,
    input  logic              prod_valid_i,
    input  logic [KW-1:0]     ksize_i,
    input  logic              dir_i,
    input  logic [KW-1:0]     variety_i,
    output logic [W*SW-1:0]   vsum_o,
    output logic [W-1:0]      vvalid_o,
    output logic [H*SW-1:0]   hsum_o,
    output logic [H-1:0]      hvalid_o
);
    import psum_adder_pkg::*;

    psum_cfg_t      cfg;
    logic [W-2:0]   pv_hist;
    logic [W-1:0]   pv_taps;
    logic [H*PW-1:0] col_vec [W];

    assign cfg.ksize  = 8'(ksize_i);
    assign cfg.offset = 8'(variety_i);
    assign cfg.dir    = stream_dir_e'(dir_i);
    assign pv_taps    = {pv_hist, prod_valid_i};

    always_ff @(posedge clk) begin
        if (rst) pv_hist <= '0;
        else     pv_hist <= {pv_hist[W-3:0], prod_valid_i};
    end

    for (genvar x = 0; x < W; x++) begin : g_col
        for (genvar r = 0; r < H; r++) begin : g_gather
            assign col_vec[x][r*PW +: PW] = prod_i[(r*W+x)*PW +: PW];
        end
        psum_col_adder #(.H(H), .PW(PW), .SW(SW)) col_i (
            .clk      (clk),
            .rst      (rst),
            .col_prod (col_vec[x]),
            .ksize    (cfg.ksize),
            .offset   (cfg.offset),
            .pv       (prod_valid_i),
            .sum_q    (vsum_o[x*SW +: SW]),
            .vld_q    (vvalid_o[x])
        );
    end

    for (genvar y = 0; y < H; y++) begin : g_row
        psum_row_adder #(.W(W), .PW(PW), .SW(SW)) row_i (
            .clk      (clk),
            .rst      (rst),
            .row_prod (prod_i[y*W*PW +: W*PW]),
            .cfg      (cfg),
            .pv_taps  (pv_taps),
            .sum_q    (hsum_o[y*SW +: SW]),
            .vld_q    (hvalid_o[y])
        );
    end

    // R1
    rst_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vvalid_o == '0) && (hvalid_o == '0) && (vsum_o == '0) && (hsum_o == '0));

    // R8
    bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(ksize_i) < 3) |=> (vvalid_o == '0) && (hvalid_o == '0));

    initial begin
        // R9
        sum_width_chk: assert (SW >= PW + $clog2(((W > H) ? W : H) + 1));
    end

endmodule

// File: tb/psum_adder_top_tb_top.sv
module psum_adder_top_tb_top;
    localparam int W  = 5;
    localparam int H  = 5;
    localparam int PW = 16;
    localparam int SW = 20;
    localparam int KW = $clog2(((W > H) ? W : H) + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [W*H*PW-1:0] prod_i = '0;
    logic              prod_valid_i = 1'b0;
    logic [KW-1:0]     ksize_i = KW'(3);
    logic              dir_i = 1'b0;
    logic [KW-1:0]     variety_i = '0;
    logic [W*SW-1:0]   vsum_o;
    logic [W-1:0]      vvalid_o;
    logic [H*SW-1:0]   hsum_o;
    logic [H-1:0]      hvalid_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    logic [W*H*PW-1:0] hist [W];
    logic [W-1:0]      pvh;

    always #4 clk = ~clk;

    psum_adder_top #(.W(W), .H(H), .PW(PW), .SW(SW)) dut_i (
        .clk(clk), .rst(rst), .prod_i(prod_i), .prod_valid_i(prod_valid_i),
        .ksize_i(ksize_i), .dir_i(dir_i), .variety_i(variety_i),
        .vsum_o(vsum_o), .vvalid_o(vvalid_o), .hsum_o(hsum_o), .hvalid_o(hvalid_o)
    );

    always @(posedge clk) begin
        if (rst) begin
            for (int d = 0; d < W; d++) hist[d] <= '0;
            pvh <= '0;
        end else begin
            hist[0] <= prod_i;
            for (int d = 1; d < W; d++) hist[d] <= hist[d-1];
            pvh <= {pvh[W-2:0], prod_valid_i};
        end
    end

    function automatic longint pget(input int d, input int y, input int x);
        logic signed [PW-1:0] v;
        v = hist[d][(y*W+x)*PW +: PW];
        return longint'(v);
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (k=%0d dir=%0d off=%0d)",
                     req, act, exp, ksize_i, dir_i, variety_i);
        end
    endtask

    task automatic check_outputs();
        int k, off, start;
        bit vok, hok;
        longint e, a;
        k   = int'(ksize_i);
        off = int'(variety_i);
        vok = (k >= 3) && (k <= H) && (off + k <= H);
        hok = (k >= 3) && (k <= W) && (dir_i || (off + k <= W));
        start = dir_i ? (W - k) : off;
        for (int x = 0; x < W; x++) begin
            logic signed [SW-1:0] s;
            e = 0;
            if (vok) for (int r = off; r < off + k; r++) e += pget(0, r, x);
            s = vsum_o[x*SW +: SW];
            a = longint'(s);
            check(vok ? "R2 vertical sum" : "R3 vertical zero", a, e);
            check("R6 vertical valid", longint'(vvalid_o[x]), longint'(vok && pvh[0]));
        end
        for (int y = 0; y < H; y++) begin
            logic signed [SW-1:0] s;
            e = 0;
            if (hok) begin
                for (int c = start; c < start + k; c++) begin
                    int d;
                    d = dir_i ? (c - start) : (start + k - 1 - c);
                    e += pget(d, y, c);
                end
            end
            s = hsum_o[y*SW +: SW];
            a = longint'(s);
            check(hok ? (dir_i ? "R5 reverse sum" : "R4 forward sum") : "R7 R8 horizontal zero", a, e);
            check("R6 horizontal valid", longint'(hvalid_o[y]), longint'(hok && pvh[k-1]));
        end
    endtask

    initial begin
        void'($urandom(17));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: state right after reset
        check("R1 reset vvalid", longint'(vvalid_o), 0);
        check("R1 reset hvalid", longint'(hvalid_o), 0);
        check("R1 reset vsum", longint'(vsum_o != '0), 0);
        check("R1 reset hsum", longint'(hsum_o != '0), 0);
        for (int k = 2; k <= 6; k++) begin
            for (int dr = 0; dr < 2; dr++) begin
                for (int off = 0; off < 4; off++) begin
                    ksize_i   = KW'(k);
                    dir_i     = dr[0];
                    variety_i = KW'(off);
                    for (int cyc = 0; cyc < 9; cyc++) begin
                        for (int i = 0; i < W*H; i++) begin
                            // R9: include extreme negative and positive values
                            if (cyc == 3) prod_i[i*PW +: PW] = {1'b1, {(PW-1){1'b0}}};
                            else if (cyc == 4) prod_i[i*PW +: PW] = {1'b0, {(PW-1){1'b1}}};
                            else prod_i[i*PW +: PW] = PW'($urandom);
                        end
                        prod_valid_i = ($urandom % 3) != 0;
                        @(negedge clk);
                        check_outputs();
                    end
                end
            end
        end
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule